// File: doc/BRIEF.md
# Edge-capture interrupt input port

This block is a one-bit, input-only port that sits on a small processor bus. It brings an external signal into the system clock domain through a synchronizer. It watches the synchronized value for rising edges and records each one in a sticky capture bit. Software can read the current pin value, read the capture bit and clear it, and set an interrupt mask.

The interrupt request has two sources, chosen by a mode input. In edge mode the request follows the masked capture bit, so it stays asserted until software clears the capture. In level mode the request follows the masked synchronized pin level. The capture bit is still updated in level mode.

The register interface is a plain word-addressed strobe interface. Reads are combinational from registered state. A write takes effect at the next clock edge.

Top module: `edge_irq_port`

## Requirements
- R1: While reset is held and right after it, the mask bit and the capture bit are 0, `irqOut` is 0, and offset 0 reads 0 (provided `pinIn` is 0 during reset).
- R2: Reading offset 0 returns, on bit 0, the value that `pinIn` had two clock edges earlier, because the synchronizer has two stages.
- R3: A 0-to-1 transition of the synchronized input sets the capture bit, which can be read on bit 0 of offset 3. The bit is set at the clock edge after the synchronized value first reads 1. It then stays set after the input falls, until a clear.
- R4: A write of any data value to offset 3 clears the capture bit at that clock edge.
- R5: If a rising edge is detected in the same cycle as a clear write to offset 3, the capture bit remains 1.
- R6: Offset 2 holds the interrupt mask in bit 0. A write stores `busWrData[0]`, and a read returns the stored value.
- R7: With `levelMode` at 0, `irqOut` is the mask bit ANDed with the capture bit.
- R8: With `levelMode` at 1, `irqOut` is the mask bit ANDed with the synchronized input, independent of the capture bit.
- R9: Writes to offsets 0 and 1 change no state. Offset 1 reads 0. Bits above bit 0 of every read are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | External asynchronous input signal |
| levelMode | input | 1 | 1 selects the level interrupt source, 0 selects the captured edge |
| busAddr | input | 2 | Register word offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for `busAddr` |
| irqOut | output | 1 | Interrupt request |

## Verification
The synchronizer-delay property compares the synchronized value with `pinIn` two cycles back. It therefore assumes that `pinIn` is 0 while reset is held. The bench keeps the pin low whenever it asserts reset, including the mid-run reset. The properties also assume that each write strobe is a single qualified cycle with a stable address. The bench changes bus inputs only one nanosecond after a rising edge. The clear-versus-edge collision is reached by placing a clear write exactly in the cycle where the synchronized input first reads 1.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] OFF_PIN  = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] OFF_CAP  = 2'd3;

  typedef struct packed {
    logic maskWr;
    logic maskVal;
    logic capClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              syncBit,
  input  logic              maskBit,
  input  logic              capBit,
  output ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] busRdData
);
  always_comb begin
    strobes.maskWr  = busWrEn && (busAddr == OFF_MASK);
    strobes.maskVal = busWrData[0];
    strobes.capClr  = busWrEn && (busAddr == OFF_CAP);
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFF_PIN:  busRdData[0] = syncBit;
      OFF_MASK: busRdData[0] = maskBit;
      OFF_CAP:  busRdData[0] = capBit;
      default:  busRdData[0] = 1'b0;
    endcase
  end
endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinIn,
  input  logic         levelMode,
  input  ctrlStrobes_t strobes,
  output logic         syncBit,
  output logic         maskBit,
  output logic         capBit,
  output logic         edgeHit,
  output logic         irqOut
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic prevSync;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= pinIn;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  assign syncBit = syncChain[SYNC_STAGES-1];
  assign edgeHit = syncBit & ~prevSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSync <= 1'b0;
      maskBit  <= 1'b0;
      capBit   <= 1'b0;
    end else begin
      prevSync <= syncBit;
      if (strobes.maskWr) maskBit <= strobes.maskVal;
      capBit <= edgeHit | (capBit & ~strobes.capClr);
    end
  end

  assign irqOut = maskBit & (levelMode ? syncBit : capBit);
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port
  import edge_irq_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              levelMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  ctrlStrobes_t strobes;
  logic syncBit, maskBit, capBit, edgeHit;

  edge_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .syncBit(syncBit), .maskBit(maskBit), .capBit(capBit),
    .strobes(strobes), .busRdData(busRdData)
  );

  edge_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .levelMode(levelMode),
    .strobes(strobes), .syncBit(syncBit), .maskBit(maskBit),
    .capBit(capBit), .edgeHit(edgeHit), .irqOut(irqOut)
  );
endmodule

// File: rtl/edge_irq_port_chk.sv
module edge_irq_port_chk
  import edge_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pinIn,
  input logic              levelMode,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              irqOut,
  input logic              syncBit,
  input logic              maskBit,
  input logic              capBit,
  input logic              edgeHit
);
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    syncBit == $past(pinIn, 2)); // R2
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> capBit); // R3 R5
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (capBit && !(busWrEn && busAddr == OFF_CAP)) |=> capBit); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_CAP && !edgeHit) |=> !capBit); // R4
  AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFF_MASK) |=> maskBit == $past(busWrData[0])); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == OFF_MASK) |=> $stable(maskBit)); // R9
  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    !maskBit |-> !irqOut); // R7
  AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && maskBit && syncBit) |-> irqOut); // R8
endmodule

bind edge_irq_port edge_irq_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .levelMode(levelMode),
  .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .irqOut(irqOut), .syncBit(syncBit), .maskBit(maskBit),
  .capBit(capBit), .edgeHit(edgeHit)
);

// File: tb/edge_irq_port_tb.sv
`timescale 1ns/1ps
module edge_irq_port_tb;
  localparam int DATA_W = 8;
  localparam int NVEC = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0;
  logic levelMode = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_port #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .levelMode(levelMode),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  // {pin, wrEn, addr[1:0], wdata bit0, levelMode, expected read bit0, expected irq}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0_0_00_0_0_0_0, // R2 idle
    8'b0_1_10_1_0_1_0, // R6 set mask
    8'b1_0_00_0_0_0_0, // R2 first stage only
    8'b1_0_00_0_0_1_0, // R2 visible after two edges
    8'b1_0_11_0_0_1_1, // R3 R7 captured
    8'b0_0_11_0_0_1_1, // R3 sticky after fall
    8'b0_1_11_0_0_0_0, // R4 clear
    8'b0_0_00_0_1_0_0, // R8 level low
    8'b1_0_00_0_1_0_0, // R8 in sync chain
    8'b1_0_00_0_1_1_1, // R8 level irq
    8'b1_0_11_0_1_1_1, // R3 capture in level mode
    8'b1_1_11_0_1_0_1, // R4 R8 clear, level irq stays
    8'b0_1_10_0_1_0_0, // R6 mask off
    8'b0_0_00_0_1_0_0, // R8 idle
    8'b0_1_01_1_0_0_0, // R9 write offset 1
    8'b0_1_00_1_0_0_0, // R9 write offset 0
    8'b0_0_10_0_0_0_0  // R9 mask unchanged
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [DATA_W-1:0] d);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    tick(); tick();
    // R1 during reset
    busAddr = 2'd2; #0.1; check("R1 mask", busRdData, '0);
    busAddr = 2'd3; #0.1; check("R1 cap", busRdData, '0);
    check("R1 irq", {7'b0, irqOut}, '0);
    rstN = 1'b1;
    tick();
    busAddr = 2'd0; #0.1; check("R1 pin", busRdData, '0);

    for (int i = 0; i < NVEC; i++) begin
      pinIn = VEC[i][7]; busWrEn = VEC[i][6]; busAddr = VEC[i][5:4];
      busWrData = {7'h55, VEC[i][3]}; levelMode = VEC[i][2];
      tick();
      busWrEn = 1'b0;
      #0.1;
      check($sformatf("vec%0d read", i), busRdData, {7'b0, VEC[i][1]});
      check($sformatf("vec%0d irq", i), {7'b0, irqOut}, {7'b0, VEC[i][0]});
    end

    // R5: clear lands in the cycle where the edge is detected
    levelMode = 1'b0;
    busWrite(2'd2, 8'h01);
    pinIn = 1'b1;
    tick(); tick();
    busWrite(2'd3, 8'hFF);
    busAddr = 2'd3; #0.1;
    check("R5 edge wins", busRdData, 8'h01);
    check("R5 R7 irq", {7'b0, irqOut}, 8'h01);
    busWrite(2'd3, 8'h00);
    busAddr = 2'd3; #0.1;
    check("R4 later clear", busRdData, 8'h00);
    check("R7 irq low", {7'b0, irqOut}, 8'h00);

    // R1 mid-run reset clears mask
    pinIn = 1'b0;
    tick(); tick();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
    busAddr = 2'd2; #0.1;
    check("R1 mask after reset", busRdData, 8'h00);
    check("R1 irq after reset", {7'b0, irqOut}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule